// File: doc/BRIEF.md
# SPI FIFO Level and Interrupt Unit

This unit holds the transmit and receive word queues of a SPI controller and turns their fill state into interrupt requests. The host reaches it through a small register port. A write to the data address queues a word for transmission, and a read from the same address takes the oldest received word. The serial engine sits on the other side. It removes transmit words and deposits received words. Fill levels, two programmable thresholds, a mask, raw and masked status, and a read-to-clear error register are all visible to the host.

The queue depth is a parameter between 2 and 256. A threshold register accepts only values that fit the queue, that is, values below the depth. Software can therefore find the depth by writing increasing values and reading each one back. A receive threshold of N-1 raises the receive-full condition once N words are waiting. The usual setting is the smaller of half the depth and the remaining transfer length, minus one. A control bit enables the unit. While that bit is clear, both queues are flushed, all flags are cleared, and data traffic is ignored.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: The level registers (address 2 for transmit, address 3 for receive) read back the number of words currently held, from 0 up to DEPTH.
- R2: Words leave each queue in the order they entered. A write to address 1 queues a transmit word, which the engine sees on eng_tx_data and removes with eng_tx_pop. A word the engine pushes with eng_rx_push is returned by a read of address 1.
- R3: A host push while the transmit queue holds DEPTH words is discarded, and it sets the sticky transmit-overflow status bit 1.
- R4: An engine push while the receive queue holds DEPTH words is discarded, and it sets the sticky receive-overflow status bit 3.
- R5: A read of address 1 while the unit is enabled and the receive queue is empty returns 0 and sets the sticky receive-underflow status bit 2.
- R6: The threshold registers (address 4 for transmit, address 5 for receive) take a written value only if it is below DEPTH. Any other write leaves the previous value in place.
- R7: Raw status bit 4 (receive-full) is 1 exactly while the unit is enabled and the receive level is greater than the receive threshold.
- R8: Raw status bit 0 (transmit-empty) is 1 exactly while the unit is enabled and the transmit level is at or below the transmit threshold.
- R9: Address 7 reads the raw status and address 8 reads the raw status ANDed with the mask (address 6, bit per source). irq is the OR of the masked bits, registered one cycle later.
- R10: A read of address 9 returns the error bits (1, 2, 3) and then clears them. Without that read the error bits stay set. A new error in the same cycle as the clear read wins.
- R11: Control bit 0 at address 0 enables the unit. While it is 0, both levels become 0, the error bits clear, and pushes and pops from either side have no effect.
- R12: After reset the enable bit, the levels, both thresholds, the mask, the raw status and irq all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, valid the cycle after reg_rd |
| eng_tx_pop | input | 1 | Engine removes the head transmit word |
| eng_tx_data | output | DW | Head transmit word |
| eng_tx_avail | output | 1 | Transmit queue is not empty |
| eng_rx_push | input | 1 | Engine deposits a received word |
| eng_rx_data | input | DW | Received word from the engine |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The hardest situation to reach is a clear read of the error register that lands while several error flags are set and both queues are partly filled. That is the point where stickiness, threshold status and levels all interact. Directed sequences first overflow both queues and underflow the receive side, so all three error bits are set before the clear read. A seeded random mix of host and engine pushes and pops then drives the queues repeatedly through their empty and full edges. Throughout, a bench model of both queues and of the flags predicts every level and status read.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int NI      = 5;
  localparam int IRQ_TXE = 0;
  localparam int IRQ_TXO = 1;
  localparam int IRQ_RXU = 2;
  localparam int IRQ_RXO = 3;
  localparam int IRQ_RXF = 4;
  localparam logic [NI-1:0] ERR_BITS = 5'b01110;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_DATA  = 4'd1,
    A_TXLVL = 4'd2,
    A_RXLVL = 4'd3,
    A_TXTHR = 4'd4,
    A_RXTHR = 4'd5,
    A_MASK  = 4'd6,
    A_RAW   = 4'd7,
    A_MSTAT = 4'd8,
    A_CLR   = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/sfi_sync_fifo.sv
module sfi_sync_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_miss  = pop & empty;
  assign dout      = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/sfi_limit_reg.sv
module sfi_limit_reg #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                                value <= '0;
    else if (wr && (wdata < DW'(DEPTH)))    value <= wdata[TW-1:0];
  end
endmodule

// File: rtl/sfi_irq_core.sv
module sfi_irq_core
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [TW-1:0] tx_thr,
  input  logic [TW-1:0] rx_thr,
  input  logic          tx_drop,
  input  logic          rx_drop,
  input  logic          rx_miss,
  input  logic          clr,
  input  logic [NI-1:0] mask,
  output logic [NI-1:0] raw,
  output logic [NI-1:0] masked,
  output logic          irq
);
  logic [2:0] err_q, err_set;

  assign err_set = {rx_drop, rx_miss, tx_drop};

  // sticky flags; a new event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst || !enable) err_q <= '0;
    else                err_q <= (err_q & {3{~clr}}) | err_set;
  end

  always_comb begin
    raw          = '0;
    raw[IRQ_TXE] = enable && (tx_level <= LW'(tx_thr));
    raw[IRQ_TXO] = err_q[0];
    raw[IRQ_RXU] = err_q[1];
    raw[IRQ_RXO] = err_q[2];
    raw[IRQ_RXF] = enable && (rx_level > LW'(rx_thr));
  end

  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_avail,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  output logic          irq
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic          ctrl_en;
  logic [NI-1:0] irq_mask;
  logic          host_push, rx_pop, clr_rd, txthr_wr, rxthr_wr;
  logic [LW-1:0] tx_level, rx_level;
  logic [TW-1:0] tx_thr, rx_thr;
  logic [DW-1:0] rx_head;
  logic          tx_empty, rx_empty;
  logic          tx_drop, tx_miss, rx_drop, rx_miss;
  logic [NI-1:0] raw, masked;
  logic [DW-1:0] rd_mux;

  assign host_push = reg_wr && (reg_addr == A_DATA) && ctrl_en;
  assign rx_pop    = reg_rd && (reg_addr == A_DATA) && ctrl_en;
  assign clr_rd    = reg_rd && (reg_addr == A_CLR);
  assign txthr_wr  = reg_wr && (reg_addr == A_TXTHR);
  assign rxthr_wr  = reg_wr && (reg_addr == A_RXTHR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      irq_mask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_en  <= reg_wdata[0];
      if (reg_addr == A_MASK) irq_mask <= reg_wdata[NI-1:0];
    end
  end

  sfi_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(!ctrl_en),
    .push(host_push), .din(reg_wdata),
    .pop(eng_tx_pop && ctrl_en), .dout(eng_tx_data),
    .level(tx_level), .empty(tx_empty),
    .push_drop(tx_drop), .pop_miss(tx_miss)
  );

  sfi_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(!ctrl_en),
    .push(eng_rx_push && ctrl_en), .din(eng_rx_data),
    .pop(rx_pop), .dout(rx_head),
    .level(rx_level), .empty(rx_empty),
    .push_drop(rx_drop), .pop_miss(rx_miss)
  );

  assign eng_tx_avail = !tx_empty;

  sfi_limit_reg #(.DW(DW), .DEPTH(DEPTH)) u_txthr (
    .clk(clk), .rst(rst), .wr(txthr_wr), .wdata(reg_wdata), .value(tx_thr)
  );

  sfi_limit_reg #(.DW(DW), .DEPTH(DEPTH)) u_rxthr (
    .clk(clk), .rst(rst), .wr(rxthr_wr), .wdata(reg_wdata), .value(rx_thr)
  );

  sfi_irq_core #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .enable(ctrl_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_drop(tx_drop), .rx_drop(rx_drop), .rx_miss(rx_miss),
    .clr(clr_rd), .mask(irq_mask),
    .raw(raw), .masked(masked), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:  rd_mux = DW'(ctrl_en);
      A_DATA:  rd_mux = (ctrl_en && !rx_empty) ? rx_head : '0;
      A_TXLVL: rd_mux = DW'(tx_level);
      A_RXLVL: rd_mux = DW'(rx_level);
      A_TXTHR: rd_mux = DW'(tx_thr);
      A_RXTHR: rd_mux = DW'(rx_thr);
      A_MASK:  rd_mux = DW'(irq_mask);
      A_RAW:   rd_mux = DW'(raw);
      A_MSTAT: rd_mux = DW'(masked);
      A_CLR:   rd_mux = DW'(raw & ERR_BITS);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_push,
  input logic          eng_tx_pop,
  input logic          txthr_wr,
  input logic [DW-1:0] wdata,
  input logic [TW-1:0] tx_thr,
  input logic [NI-1:0] mask,
  input logic [NI-1:0] raw,
  input logic          irq,
  input logic          clr_rd
);
  // R1: levels never exceed the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  // R3: a push into a full transmit queue changes nothing but the flag
  a_r3_tx_full_push: assert property (@(posedge clk) disable iff (rst)
    (enable && tx_push && !eng_tx_pop && tx_level == LW'(DEPTH))
      |=> (tx_level == LW'(DEPTH)) && raw[IRQ_TXO]);

  // R6: out-of-range threshold writes are not kept
  a_r6_thr_reject: assert property (@(posedge clk) disable iff (rst)
    (txthr_wr && wdata >= DW'(DEPTH)) |=> $stable(tx_thr));

  // R9: with every source masked the request stays low
  a_r9_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  // R10: error flags do not drop without a clear read or a disable
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr_rd) |=> ((raw & ERR_BITS & $past(raw)) == ($past(raw) & ERR_BITS)));

  // R11: a disabled unit flushes both queues
  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (tx_level == '0) && (rx_level == '0));
endmodule

bind spi_fifo_irq_unit sfi_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .enable(ctrl_en),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_push(host_push), .eng_tx_pop(eng_tx_pop),
  .txthr_wr(txthr_wr), .wdata(reg_wdata), .tx_thr(tx_thr),
  .mask(irq_mask), .raw(raw), .irq(irq), .clr_rd(clr_rd)
);

// File: tb/spi_fifo_irq_unit_test.sv
module spi_fifo_irq_unit_test;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam logic [3:0] RCTL = 0, RDAT = 1, RTXL = 2, RRXL = 3, RTXT = 4,
                         RRXT = 5, RMSK = 6, RRAW = 7, RMST = 8, RCLR = 9;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic eng_tx_pop = 0, eng_tx_avail, eng_rx_push = 0, irq;
  logic [DW-1:0] eng_tx_data, eng_rx_data = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] txq[$], rxq[$];
  bit m_en = 0, m_txo = 0, m_rxu = 0, m_rxo = 0;
  int m_txthr = 0, m_rxthr = 0;
  logic [4:0] m_mask = 0;

  function automatic logic [31:0] exp_raw();
    logic [31:0] r = 0;
    r[0] = m_en && (txq.size() <= m_txthr);
    r[1] = m_txo;
    r[2] = m_rxu;
    r[3] = m_rxo;
    r[4] = m_en && (rxq.size() > m_rxthr);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic host_push(logic [31:0] v);
    wr(RDAT, v);
    if (m_en) begin
      if (txq.size() == DEPTH) m_txo = 1; else txq.push_back(v);
    end
  endtask

  task automatic host_pop(string tag);
    logic [31:0] d, e;
    rd(RDAT, d);
    e = 0;
    if (m_en) begin
      if (rxq.size() > 0) e = rxq.pop_front(); else m_rxu = 1;
    end
    chk(tag, d, e);
  endtask

  task automatic eng_push(logic [31:0] v);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = v;
    @(negedge clk); eng_rx_push = 0;
    if (m_en) begin
      if (rxq.size() == DEPTH) m_rxo = 1; else rxq.push_back(v);
    end
  endtask

  task automatic eng_pop(string tag);
    @(negedge clk);
    chk({tag, " avail"}, eng_tx_avail, (m_en && txq.size() > 0));
    if (m_en && txq.size() > 0) chk({tag, " data"}, eng_tx_data, txq[0]);
    eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
    if (m_en && txq.size() > 0) void'(txq.pop_front());
  endtask

  task automatic chk_state(string tag);
    logic [31:0] d;
    rd(RTXL, d); chk({tag, " R1 tx level"}, d, txq.size());
    rd(RRXL, d); chk({tag, " R1 rx level"}, d, rxq.size());
    rd(RRAW, d); chk({tag, " R7/R8 raw"}, d, exp_raw());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 0;

    // R12 reset values
    rd(RCTL, d); chk("R12 ctrl", d, 0);
    rd(RTXT, d); chk("R12 tx threshold", d, 0);
    rd(RRXT, d); chk("R12 rx threshold", d, 0);
    rd(RMSK, d); chk("R12 mask", d, 0);
    chk_state("R12");
    chk("R12 irq", irq, 0);

    // R11 pushes ignored while disabled
    host_push(32'hDEAD);
    eng_push(32'hBEEF);
    chk_state("R11 disabled");

    // R6 depth probe
    wr(RTXT, DEPTH - 1); rd(RTXT, d); chk("R6 keep depth-1", d, DEPTH - 1);
    wr(RTXT, DEPTH);     rd(RTXT, d); chk("R6 reject depth", d, DEPTH - 1);
    wr(RTXT, 255);       rd(RTXT, d); chk("R6 reject 255", d, DEPTH - 1);
    m_txthr = DEPTH - 1;
    wr(RRXT, 3);    rd(RRXT, d); chk("R6 rx keep", d, 3);
    wr(RRXT, 1000); rd(RRXT, d); chk("R6 rx reject", d, 3);
    m_rxthr = 3;

    wr(RCTL, 1); m_en = 1;
    chk_state("R8 enabled empty");

    // R2 R3 transmit fill and overflow
    for (int i = 0; i < DEPTH; i++) host_push(i * 3 + 7);
    chk_state("R1 tx full");
    host_push(32'h1111);
    chk_state("R3 tx overflow");
    for (int i = 0; i < DEPTH; i++) eng_pop("R2 tx order");
    eng_pop("R2 tx empty");

    // R7 receive threshold at level-1 setting
    for (int i = 0; i < 3; i++) eng_push(32'h100 + i);
    chk_state("R7 below");
    eng_push(32'h103);
    chk_state("R7 at level");
    for (int i = 0; i < 4; i++) host_pop("R2 rx order");
    host_pop("R5 underflow zero");
    chk_state("R5 underflow flag");

    // R4 receive overflow
    for (int i = 0; i <= DEPTH; i++) eng_push(32'h200 + i);
    chk_state("R4 rx overflow");
    for (int i = 0; i < DEPTH; i++) host_pop("R2 rx drain");

    // R9 mask and irq
    wr(RMSK, 5'b00010); m_mask = 5'b00010;
    @(negedge clk);
    chk("R9 irq on", irq, 1);
    rd(RMST, d); chk("R9 masked", d, exp_raw() & m_mask);
    wr(RMSK, 0); m_mask = 0;
    @(negedge clk);
    chk("R9 irq off", irq, 0);

    // R10 read to clear
    rd(RRAW, d); chk("R10 sticky held", d, exp_raw());
    rd(RCLR, d); chk("R10 clear value", d, 32'hE);
    m_txo = 0; m_rxu = 0; m_rxo = 0;
    chk_state("R10 after clear");

    // R8 transmit threshold crossing
    wr(RTXT, 4); m_txthr = 4;
    for (int i = 0; i < 5; i++) host_push(32'h300 + i);
    chk_state("R8 above");
    eng_pop("R8 pop");
    chk_state("R8 at threshold");

    // random mix
    wr(RRXT, 4); m_rxthr = 4;
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 5)
        0: host_push($urandom);
        1: host_pop("R2 random rx");
        2: eng_push($urandom);
        3: eng_pop("R2 random tx");
        default: begin
          rd(RCLR, d); chk("R10 random clear", d, exp_raw() & 32'hE);
          m_txo = 0; m_rxu = 0; m_rxo = 0;
        end
      endcase
      if (n % 6 == 0) chk_state("random");
    end

    // R11 disable flush
    for (int i = 0; i < 3; i++) host_push(i);
    eng_push(9);
    wr(RCTL, 0); m_en = 0;
    txq.delete(); rxq.delete(); m_txo = 0; m_rxu = 0; m_rxo = 0;
    @(negedge clk);
    chk_state("R11 flushed");
    wr(RCTL, 1); m_en = 1;
    chk_state("R11 re-enabled");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule